// File: doc/BRIEF.md
# Multicast Copy Fan-out Engine

This block sits between a forwarding lookup and a queue manager. It takes one forwarding decision at a time. Each decision carries a packet buffer handle, the IPv4 destination address, a ten-bit target vector, a queue ID, a stats index and, for unicast, a single target index. Target indices 0 to 4 name physical output ports and indices 5 to 9 name plugin targets.

For a multicast decision, the block derives the Ethernet group MAC address from the IP destination. It stores that address, the stats index and a copy count in the packet's buffer descriptor through a plain write port, one 32-bit word per cycle. It then issues one enqueue request per set bit of the vector, lowest index first, on a valid/ready interface. Every copy shares the same queue ID and the same descriptor, so the queue manager and the transmit side find one MAC address and one reference count for all copies.

A unicast decision goes straight to a single enqueue, with no descriptor write. A multicast decision with an empty vector, or a unicast decision with an index outside 0 to 9, is dropped: the buffer handle is handed back on a one-cycle release strobe.

Top module: `mcast_fanout`

## Requirements
- R1: After reset `req_ready` is 1 and `dw_valid`, `enq_valid` and `free_valid` are 0.
- R2: The derived MAC is 01:00:5E in the upper 24 bits, then a 0 bit, then bits 22:0 of `req_dip`.
- R3: A multicast decision with a non-empty vector causes exactly three descriptor writes in consecutive cycles, all to `dw_buf` equal to the handle, in this order: word index 3 with data {MAC[47:32], stats index in bits 15:0}, then word index 4 with MAC[31:0], then word index 5 with the copy count in bits 3:0 and zeros above.
- R4: The copy count written is the number of set bits in the target vector.
- R5: No enqueue is issued before the third descriptor write, and the first enqueue request is presented in the cycle right after it. At most one of `dw_valid`, `enq_valid` and `free_valid` is high in any cycle.
- R6: One enqueue is issued per set vector bit, in ascending bit order. `enq_dest` equals the bit index and `enq_buf` equals the handle.
- R7: An enqueue to a port target (index below 5) carries the request's queue ID. An enqueue to a plugin target (index 5 to 9) carries a queue ID of 0.
- R8: While `enq_valid` is 1 and `enq_ready` is 0, the enqueue outputs hold stable. No copy is lost or repeated under backpressure.
- R9: A multicast decision with an all-zero vector gives no descriptor write and no enqueue. It gives exactly one cycle of `free_valid`, with `free_buf` equal to the handle, and then `free_valid` returns to 0.
- R10: A unicast decision (`req_mcast`=0) with `req_port` from 0 to 9 gives no descriptor write and exactly one enqueue to `req_port`, under the queue ID rule of R7. A unicast decision with `req_port` of 10 or more is released as in R9.
- R11: `req_ready` is 1 only when no decision is in progress. While it is 1, no write, enqueue or release is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Decision offered |
| req_ready | output | 1 | Decision accepted when high with req_valid |
| req_mcast | input | 1 | 1 = multicast decision, 0 = unicast |
| req_buf | input | 24 | Packet buffer handle |
| req_dip | input | 32 | IPv4 destination address |
| req_cvec | input | 10 | Target vector (bits 0-4 ports, 5-9 plugins) |
| req_port | input | 4 | Unicast target index |
| req_qid | input | 17 | Queue ID |
| req_stats | input | 16 | Stats index |
| dw_valid | output | 1 | Descriptor word write strobe |
| dw_buf | output | 24 | Descriptor (buffer handle) written |
| dw_word | output | 3 | Word index inside the descriptor |
| dw_data | output | 32 | Word data |
| enq_valid | output | 1 | Enqueue request valid |
| enq_ready | input | 1 | Queue manager accepts the request |
| enq_buf | output | 24 | Buffer handle of the copy |
| enq_dest | output | 4 | Target index of the copy |
| enq_qid | output | 17 | Queue ID of the copy |
| free_valid | output | 1 | Buffer release strobe |
| free_buf | output | 24 | Buffer handle released |

## Verification
A corrupted pending-copy mask shows up at the enqueue port within one accepted copy: a target index appears twice, out of ascending order, or is missing before `req_ready` rises again. A wrong captured MAC, stats value or count shows in the first three write cycles after acceptance, before any copy leaves. A sequencer stuck in a busy state shows as `req_ready` staying low past the number of cycles the vector and the backpressure pattern allow. A sequencer that leaves busy too early shows as a copy count that differs from the number of enqueues.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
   // Sequencer states of the fan-out engine
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_HI,
      ST_WR_LO,
      ST_WR_REF,
      ST_ENQ,
      ST_DROP
   } mcf_state_e;

   // Group MAC prefix for IPv4 multicast
   localparam logic [23:0] MAC_PREFIX = 24'h01005E;

   // Descriptor word indices, decoded by the neighbouring blocks
   localparam logic [2:0] WORD_MAC_HI = 3'd3;
   localparam logic [2:0] WORD_MAC_LO = 3'd4;
   localparam logic [2:0] WORD_REF    = 3'd5;
endpackage

// File: rtl/mcf_mac_map.sv
module mcf_mac_map
   import mcf_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] dip_i,
   output logic [47:0]       mac_o
);
   if (ADDR_W < 23) begin : g_bad_width
      $error("mcf_mac_map: address narrower than 23 bits");
   end

   // prefix, one zero bit, then the low 23 address bits
   assign mac_o = {MAC_PREFIX, 1'b0, dip_i[22:0]};
endmodule

// File: rtl/mcf_popcount.sv
module mcf_popcount #(
   parameter int W     = 10,
   parameter int CNT_W = 4
) (
   input  logic [W-1:0]     vec_i,
   output logic [CNT_W-1:0] cnt_o
);
   if (W >= (1 << CNT_W)) begin : g_bad_width
      $error("mcf_popcount: count field too narrow for vector");
   end

   logic [CNT_W-1:0] acc [W+1];
   assign acc[0] = '0;

   for (genvar i = 0; i < W; i++) begin : g_add
      assign acc[i+1] = acc[i] + CNT_W'(vec_i[i]);
   end

   assign cnt_o = acc[W];
endmodule

// File: rtl/mcf_lowbit.sv
module mcf_lowbit #(
   parameter int W     = 10,
   parameter int IDX_W = 4
) (
   input  logic [W-1:0]     vec_i,
   output logic [W-1:0]     onehot_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   if (W > (1 << IDX_W)) begin : g_bad_width
      $error("mcf_lowbit: index too narrow for vector");
   end

   logic [W:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_chain
      assign onehot_o[i] = vec_i[i] & ~seen[i];
      assign seen[i+1]   = seen[i] | vec_i[i];
   end

   assign any_o = seen[W];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (onehot_o[i]) idx_o = IDX_W'(i);
      end
   end

   // lowest set bit chosen: exactly one bit when any is set
   always_comb begin
      if (any_o) assert_one_pick_R6: assert ($onehot(onehot_o));
   end
endmodule

// File: rtl/mcast_fanout.sv
module mcast_fanout
   import mcf_pkg::*;
#(
   parameter int NUM_PORTS   = 5,
   parameter int NUM_PLUGINS = 5,
   parameter int BUF_W       = 24,
   parameter int QID_W       = 17,
   parameter int STATS_W     = 16,
   parameter int REF_W       = 4,
   localparam int CV_W       = NUM_PORTS + NUM_PLUGINS,
   localparam int DEST_W     = $clog2(CV_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_mcast,
   input  logic [BUF_W-1:0]   req_buf,
   input  logic [31:0]        req_dip,
   input  logic [CV_W-1:0]    req_cvec,
   input  logic [DEST_W-1:0]  req_port,
   input  logic [QID_W-1:0]   req_qid,
   input  logic [STATS_W-1:0] req_stats,
   output logic               dw_valid,
   output logic [BUF_W-1:0]   dw_buf,
   output logic [2:0]         dw_word,
   output logic [31:0]        dw_data,
   output logic               enq_valid,
   input  logic               enq_ready,
   output logic [BUF_W-1:0]   enq_buf,
   output logic [DEST_W-1:0]  enq_dest,
   output logic [QID_W-1:0]   enq_qid,
   output logic               free_valid,
   output logic [BUF_W-1:0]   free_buf
);
   localparam logic [DEST_W-1:0] PORT_LIM = DEST_W'(NUM_PORTS);

   if (STATS_W > 16) begin : g_bad_stats
      $error("mcast_fanout: stats index must fit in 16 bits");
   end
   if (CV_W >= (1 << REF_W)) begin : g_bad_ref
      $error("mcast_fanout: reference count too narrow for target count");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("mcast_fanout: at least one port required");
   end

   // ---------------- captured decision ----------------
   mcf_state_e         state_q, state_d;
   logic [BUF_W-1:0]   buf_q;
   logic [47:0]        mac_q;
   logic [STATS_W-1:0] stats_q;
   logic [QID_W-1:0]   qid_q;
   logic [CV_W-1:0]    pend_q, pend_d;
   logic [REF_W-1:0]   ref_q;

   // ---------------- helpers ----------------
   logic [47:0]       mac_in;
   logic [REF_W-1:0]  ref_in;
   logic [CV_W-1:0]   uni_mask;
   logic [CV_W-1:0]   load_mask;
   logic [CV_W-1:0]   pick_oh;
   logic [DEST_W-1:0] pick_idx;
   logic              pick_any;
   logic              accept;

   mcf_mac_map #(.ADDR_W(32)) u_mac (
      .dip_i (req_dip),
      .mac_o (mac_in)
   );

   mcf_popcount #(.W(CV_W), .CNT_W(REF_W)) u_pop (
      .vec_i (req_cvec),
      .cnt_o (ref_in)
   );

   mcf_lowbit #(.W(CV_W), .IDX_W(DEST_W)) u_pick (
      .vec_i    (pend_q),
      .onehot_o (pick_oh),
      .idx_o    (pick_idx),
      .any_o    (pick_any)
   );

   // unicast target as a one-bit mask, empty when out of range
   for (genvar i = 0; i < CV_W; i++) begin : g_umask
      assign uni_mask[i] = (req_port == DEST_W'(i));
   end

   assign load_mask = req_mcast ? req_cvec : uni_mask;
   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   // ---------------- sequencer ----------------
   always_comb begin
      state_d = state_q;
      pend_d  = pend_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               pend_d = load_mask;
               if (load_mask == '0)
                  state_d = ST_DROP;
               else if (req_mcast)
                  state_d = ST_WR_HI;
               else
                  state_d = ST_ENQ;
            end
         end
         ST_WR_HI:  state_d = ST_WR_LO;
         ST_WR_LO:  state_d = ST_WR_REF;
         ST_WR_REF: state_d = ST_ENQ;
         ST_ENQ: begin
            if (enq_ready) begin
               pend_d = pend_q & ~pick_oh;
               if (pend_d == '0) state_d = ST_IDLE;
            end
         end
         ST_DROP: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         buf_q   <= '0;
         mac_q   <= '0;
         stats_q <= '0;
         qid_q   <= '0;
         ref_q   <= '0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         if (accept) begin
            buf_q   <= req_buf;
            mac_q   <= mac_in;
            stats_q <= req_stats;
            qid_q   <= req_qid;
            ref_q   <= ref_in;
         end
      end
   end

   // ---------------- descriptor write port ----------------
   always_comb begin
      dw_valid = 1'b0;
      dw_word  = WORD_MAC_HI;
      dw_data  = '0;
      unique case (state_q)
         ST_WR_HI: begin
            dw_valid = 1'b1;
            dw_word  = WORD_MAC_HI;
            dw_data  = {mac_q[47:32], 16'(stats_q)};
         end
         ST_WR_LO: begin
            dw_valid = 1'b1;
            dw_word  = WORD_MAC_LO;
            dw_data  = mac_q[31:0];
         end
         ST_WR_REF: begin
            dw_valid = 1'b1;
            dw_word  = WORD_REF;
            dw_data  = 32'(ref_q);
         end
         default: ;
      endcase
   end
   assign dw_buf = buf_q;

   // ---------------- enqueue and release ----------------
   assign enq_valid  = (state_q == ST_ENQ) && pick_any;
   assign enq_buf    = buf_q;
   assign enq_dest   = pick_idx;
   assign enq_qid    = (pick_idx < PORT_LIM) ? qid_q : '0;
   assign free_valid = (state_q == ST_DROP);
   assign free_buf   = buf_q;

   // ---------------- assertions ----------------
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!dw_valid && !enq_valid && !free_valid));

   assert_ref_then_enq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_valid && dw_word == WORD_REF) |=> enq_valid);

   assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dw_valid, enq_valid, free_valid}));

   assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && $past(enq_valid && enq_ready)) |-> (enq_dest > $past(enq_dest)));

   assert_dest_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      enq_valid |-> (enq_dest < DEST_W'(CV_W)));

   assert_plugin_qid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_dest >= PORT_LIM) |-> (enq_qid == '0));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && !enq_ready) |=>
         (enq_valid && $stable(enq_dest) && $stable(enq_qid) && $stable(enq_buf)));

   assert_free_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      free_valid |=> (!free_valid && req_ready));

   assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/mcast_fanout_tb.sv
`timescale 1ns/1ps
module mcast_fanout_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_mcast = 1'b0;
   logic [23:0] req_buf = '0;
   logic [31:0] req_dip = '0;
   logic [9:0]  req_cvec = '0;
   logic [3:0]  req_port = '0;
   logic [16:0] req_qid = '0;
   logic [15:0] req_stats = '0;
   logic        dw_valid;
   logic [23:0] dw_buf;
   logic [2:0]  dw_word;
   logic [31:0] dw_data;
   logic        enq_valid;
   logic        enq_ready = 1'b0;
   logic [23:0] enq_buf;
   logic [3:0]  enq_dest;
   logic [16:0] enq_qid;
   logic        free_valid;
   logic [23:0] free_buf;

   int total = 0;
   int bad = 0;
   int ready_pct = 70;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mcast_fanout u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_mcast(req_mcast),
      .req_buf(req_buf), .req_dip(req_dip), .req_cvec(req_cvec),
      .req_port(req_port), .req_qid(req_qid), .req_stats(req_stats),
      .dw_valid(dw_valid), .dw_buf(dw_buf), .dw_word(dw_word), .dw_data(dw_data),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_buf(enq_buf),
      .enq_dest(enq_dest), .enq_qid(enq_qid),
      .free_valid(free_valid), .free_buf(free_buf)
   );

   function automatic logic [47:0] exp_mac(logic [31:0] dip);
      return {24'h01005E, 1'b0, dip[22:0]};
   endfunction

   function automatic int popc(logic [9:0] v);
      int n = 0;
      for (int i = 0; i < 10; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic txn(bit mc, logic [23:0] b, logic [31:0] dip, logic [9:0] cv,
                      logic [3:0] port, logic [16:0] qid, logic [15:0] st);
      logic [2:0]  wword [8];
      logic [31:0] wdata [8];
      logic [23:0] wbuf  [8];
      logic [3:0]  edest [16];
      logic [16:0] eqid  [16];
      logic [23:0] ebuf  [16];
      int nw = 0, ne = 0, nf = 0, cyc = 0, k = 0;
      bit early = 1'b0, busy_seen_ready = 1'b0;
      logic [23:0] fb = '0;
      logic [47:0] mac;
      logic [9:0]  tgt;
      bit drop;

      @(negedge clk);
      req_valid = 1'b1; req_mcast = mc; req_buf = b; req_dip = dip;
      req_cvec = cv; req_port = port; req_qid = qid; req_stats = st;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      forever begin
         enq_ready = ($urandom_range(99) < ready_pct);
         #1;
         if (cyc == 0 && req_ready) busy_seen_ready = 1'b1;
         if (dw_valid && nw < 8) begin
            wword[nw] = dw_word; wdata[nw] = dw_data; wbuf[nw] = dw_buf;
         end
         if (dw_valid) nw++;
         if (enq_valid && enq_ready) begin
            if (nw < 3 && mc) early = 1'b1;
            if (ne < 16) begin edest[ne] = enq_dest; eqid[ne] = enq_qid; ebuf[ne] = enq_buf; end
            ne++;
         end
         if (free_valid) begin nf++; fb = free_buf; end
         if (req_ready) break;
         cyc++;
         if (cyc > 400) begin
            chk(1'b0, "R11", "decision never completed", cyc, 0);
            break;
         end
         @(negedge clk);
      end
      enq_ready = 1'b0;

      chk(!busy_seen_ready, "R11", "req_ready high while busy", busy_seen_ready, 0);
      mac  = exp_mac(dip);
      tgt  = mc ? cv : ((port < 10) ? (10'd1 << port) : 10'd0);
      drop = (tgt == 10'd0);

      if (drop) begin
         chk(nw == 0, mc ? "R9" : "R10", "writes on drop", nw, 0);
         chk(ne == 0, mc ? "R9" : "R10", "enqueues on drop", ne, 0);
         chk(nf == 1, mc ? "R9" : "R10", "release count", nf, 1);
         chk(fb == b, mc ? "R9" : "R10", "released handle", fb, b);
      end else begin
         chk(nf == 0, "R9", "release on forwarded decision", nf, 0);
         if (mc) begin
            chk(nw == 3, "R3", "write count", nw, 3);
            if (nw == 3) begin
               chk(wword[0] == 3'd3 && wword[1] == 3'd4 && wword[2] == 3'd5, "R3",
                   "word order", {wword[0], wword[1], wword[2]}, 9'o345);
               chk(wbuf[0] == b && wbuf[1] == b && wbuf[2] == b, "R3", "write handle", wbuf[2], b);
               chk(wdata[0] == {mac[47:32], st}, "R2", "mac hi word", wdata[0], {mac[47:32], st});
               chk(wdata[1] == mac[31:0], "R2", "mac lo word", wdata[1], mac[31:0]);
               chk(wdata[2] == 32'(popc(cv)), "R4", "copy count", wdata[2], popc(cv));
            end
            chk(!early, "R5", "enqueue before writes", early, 0);
         end else begin
            chk(nw == 0, "R10", "unicast wrote descriptor", nw, 0);
         end
         chk(ne == popc(tgt), mc ? "R8" : "R10", "enqueue count", ne, popc(tgt));
         for (int i = 0; i < 10; i++) begin
            if (tgt[i] && k < ne && k < 16) begin
               chk(edest[k] == 4'(i), "R6", "target order", edest[k], i);
               chk(ebuf[k] == b, "R6", "copy handle", ebuf[k], b);
               chk(eqid[k] == ((i < 5) ? qid : 17'd0), "R7", "copy qid", eqid[k],
                   (i < 5) ? qid : 17'd0);
               k++;
            end
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=expired expected=complete");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0101));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready && !dw_valid && !enq_valid && !free_valid, "R1", "outputs in reset",
          {req_ready, dw_valid, enq_valid, free_valid}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !dw_valid && !enq_valid && !free_valid, "R1", "outputs after reset",
          {req_ready, dw_valid, enq_valid, free_valid}, 4'b1000);

      // directed corner cases
      txn(1'b1, 24'hABCDE1, 32'hFFFFFFFF, 10'h3FF, 4'd0, 17'h1F0F0, 16'hBEEF); // all targets, bit 23 masked (R2)
      txn(1'b1, 24'h000010, 32'hE0000001, 10'h001, 4'd0, 17'h00005, 16'h0001); // lowest only
      txn(1'b1, 24'h000020, 32'hEF7F1234, 10'h200, 4'd0, 17'h0ABCD, 16'h0002); // highest plugin, qid 0 (R7)
      txn(1'b1, 24'h000030, 32'hE1020304, 10'h000, 4'd0, 17'h00001, 16'h0003); // empty vector (R9)
      txn(1'b0, 24'h000040, 32'h0A000001, 10'h000, 4'd4, 17'h12345, 16'h0004); // unicast port (R10)
      txn(1'b0, 24'h000050, 32'h0A000002, 10'h3FF, 4'd7, 17'h12345, 16'h0005); // unicast plugin
      txn(1'b0, 24'h000060, 32'h0A000003, 10'h000, 4'd12, 17'h00007, 16'h0006); // bad index drop
      ready_pct = 10;                                                          // heavy backpressure (R8)
      txn(1'b1, 24'h000070, 32'hE8ABCDEF, 10'h2A5, 4'd0, 17'h00033, 16'h0007);
      ready_pct = 100;
      txn(1'b1, 24'h000080, 32'hE8ABCDEF, 10'h15A, 4'd0, 17'h00044, 16'h0008);

      // constrained random decisions
      for (int n = 0; n < 150; n++) begin
         bit mc;
         logic [9:0] cv;
         ready_pct = 20 + int'($urandom_range(80));
         mc = ($urandom_range(3) != 0);
         cv = ($urandom_range(9) == 0) ? 10'd0 : 10'($urandom);
         txn(mc, 24'($urandom), $urandom, cv, 4'($urandom_range(11)),
             17'($urandom), 16'($urandom));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule